// File: doc/BRIEF.md
# Two-Processor Level Interrupt Aggregator

This block gathers a parameterised number of level-sensitive interrupt sources, arranged in groups of 32, and drives one interrupt output per processor. Every processor owns a private register bank on a simple 32-bit register bus (address, write enable, write data, read data). A bank contains one plain read/write enable word per group, followed directly by one read-only status word per group. The status words show the synchronised raw state of the sources whatever the enables hold. A processor's output is raised while at least one source is both pending and enabled in that processor's bank.

Software changes enables by reading an enable word, editing it and writing the whole word back; there are no set-only or clear-only registers. Inside each bank the word order is reversed: register word 0 serves the highest-numbered 32 sources, and the last word serves sources 0 to 31. Sources cross two flip-flops before they reach status, and each output is registered. Read data is registered, so it is valid one clock after the address is presented.

Top module: `l1irq_agg`

## Requirements
- R1: After reset every enable bit of both banks is 0, both interrupt outputs are low and read data is 0.
- R2: A write to an enable word replaces all 32 bits of that word, and a read returns the last value written to it.
- R3: Register word k of a bank (enable at offset 4k, status at offset 4*NUM_GROUPS+4k) covers sources (NUM_GROUPS-1-k)*32 to (NUM_GROUPS-1-k)*32+31, bit b standing for the lowest source of that range plus b; with 4 groups, status offset 0x10 holds sources 96..127 and offset 0x1C holds sources 0..31.
- R4: A status word returns the synchronised raw source levels, the same in both banks, independent of any enable bit.
- R5: Writes to status offsets change no enable bit and no status value.
- R6: Reads from offsets at or beyond 16*NUM_GROUPS bytes (past both banks) return 0, and writes there change no enable bit.
- R7: Interrupt output c is high in the cycle after some source is set in status and enabled in bank c, and low in the cycle after no such source exists.
- R8: A source enabled in only one bank raises only that processor's output.
- R9: A source that rises is seen on an enabled output after exactly three rising clock edges (two synchroniser flops and the output register), not after two.
- R10: Bank 1 starts at byte offset 8*NUM_GROUPS, directly after bank 0 at offset 0, and has the same internal layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_GROUPS*32 | Level-sensitive interrupt sources, bit i is source i |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data for the address of the previous cycle |
| irq_o | output | NUM_CPUS | Interrupt output per processor |

## Verification
On every cycle the assertions check that each output follows the registered reduction of status and that bank's enables, that status equals the source vector two cycles earlier, that writes to status or unmapped offsets leave every enable untouched, and that unmapped reads return 0. Only the bench scenarios can show the address layout itself: that the reversed word order and the second bank's base land on the right sources, that a write replaces a whole word, that processors stay isolated, and the exact three-edge latency from a source to its output.

// File: rtl/l1irq_pkg.sv
package l1irq_pkg;

  localparam int unsigned SRC_PER_WORD = 32;

  typedef logic [SRC_PER_WORD-1:0] word_t;

  // Decoded register access
  typedef struct packed {
    logic       hit;      // address falls inside one of the banks
    logic       is_stat;  // status half of the bank
    logic [7:0] cpu;      // bank index
    logic [7:0] grp;      // source group, already reversed from register word
  } dec_t;

endpackage

// File: rtl/l1irq_rst_sync.sv
module l1irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/l1irq_sync.sv
module l1irq_sync #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;

endmodule

// File: rtl/l1irq_addr_dec.sv
module l1irq_addr_dec
  import l1irq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned NUM_CPUS   = 2,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  localparam int unsigned BANK_WORDS = 2 * NUM_GROUPS;
  localparam int unsigned MAP_WORDS  = BANK_WORDS * NUM_CPUS;

  always_comb begin
    int unsigned widx;
    int unsigned loc;
    int unsigned regk;
    widx          = 32'(addr_i[ADDR_W-1:2]);
    loc           = widx % BANK_WORDS;
    regk          = loc % NUM_GROUPS;
    dec_o.hit     = (widx < MAP_WORDS);
    dec_o.is_stat = (loc >= NUM_GROUPS);
    dec_o.cpu     = 8'(widx / BANK_WORDS);
    // reversed order: register word 0 maps to the top source group
    dec_o.grp     = 8'(NUM_GROUPS - 1 - regk);
  end

endmodule

// File: rtl/l1irq_bank.sv
module l1irq_bank
  import l1irq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned CPU_IDX    = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we_i,
  input  dec_t                                dec_i,
  input  word_t                               wdata_i,
  input  logic [NUM_GROUPS*SRC_PER_WORD-1:0]  status_i,
  output logic [NUM_GROUPS*SRC_PER_WORD-1:0]  en_o,
  output word_t                               rd_o,
  output logic                                irq_o
);

  localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic          sel;
  logic          wr_en;
  logic [GW-1:0] gsel;
  word_t         en_q [NUM_GROUPS];
  logic          pend;
  logic          irq_q;

  assign gsel  = dec_i.grp[GW-1:0];
  assign sel   = dec_i.hit && (dec_i.cpu == 8'(CPU_IDX));
  assign wr_en = we_i && sel && !dec_i.is_stat;

  // one enable word per source group, each with its own load enable
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_word
    logic  ld;
    word_t nxt;

    always_comb begin
      ld  = wr_en && (gsel == GW'(g));
      nxt = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g] <= '0;
      end else if (ld) begin
        en_q[g] <= nxt;
      end
    end

    assign en_o[g*SRC_PER_WORD +: SRC_PER_WORD] = en_q[g];
  end

  // read path of this bank, zero when not addressed
  always_comb begin
    rd_o = '0;
    if (sel) begin
      if (dec_i.is_stat) begin
        rd_o = status_i[int'(gsel)*SRC_PER_WORD +: SRC_PER_WORD];
      end else begin
        rd_o = en_q[gsel];
      end
    end
  end

  assign pend = |(status_i & en_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= pend;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/l1irq_agg.sv
module l1irq_agg
  import l1irq_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned NUM_CPUS   = 2,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                               clk,
  input  logic                               arst_n,
  input  logic [NUM_GROUPS*SRC_PER_WORD-1:0] src_i,
  input  logic [ADDR_W-1:0]                  bus_addr_i,
  input  logic                               bus_we_i,
  input  logic [SRC_PER_WORD-1:0]            bus_wdata_i,
  output logic [SRC_PER_WORD-1:0]            bus_rdata_o,
  output logic [NUM_CPUS-1:0]                irq_o
);

  localparam int unsigned NSRC = NUM_GROUPS * SRC_PER_WORD;

  logic                           rst_n;
  logic [NSRC-1:0]                status_q;
  dec_t                           dec;
  logic [NUM_CPUS-1:0][NSRC-1:0]  en_all;
  word_t                          rd_bank [NUM_CPUS];
  word_t                          rdata_d;
  word_t                          rdata_q;

  l1irq_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  l1irq_sync #(.WIDTH(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (status_q)
  );

  l1irq_addr_dec #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_CPUS   (NUM_CPUS),
    .ADDR_W     (ADDR_W)
  ) u_dec (
    .addr_i (bus_addr_i),
    .dec_o  (dec)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    l1irq_bank #(
      .NUM_GROUPS (NUM_GROUPS),
      .CPU_IDX    (c)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (bus_we_i),
      .dec_i    (dec),
      .wdata_i  (bus_wdata_i),
      .status_i (status_q),
      .en_o     (en_all[c]),
      .rd_o     (rd_bank[c]),
      .irq_o    (irq_o[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      rdata_d = rdata_d | rd_bank[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/l1irq_agg_chk.sv
module l1irq_agg_chk #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned NUM_CPUS   = 2,
  parameter int unsigned ADDR_W     = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NUM_GROUPS*32-1:0]              src_i,
  input logic [NUM_GROUPS*32-1:0]              status,
  input logic [NUM_CPUS-1:0][NUM_GROUPS*32-1:0] en_all,
  input logic [ADDR_W-1:0]                     addr,
  input logic                                  we,
  input logic [31:0]                           rdata,
  input logic [NUM_CPUS-1:0]                   irq
);

  localparam int unsigned BANK_WORDS = 2 * NUM_GROUPS;
  localparam int unsigned MAP_WORDS  = BANK_WORDS * NUM_CPUS;

  logic [1:0] cyc;
  logic       unmapped;
  logic       stat_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 2'd0;
    end else if (cyc != 2'd3) begin
      cyc <= cyc + 2'd1;
    end
  end

  assign unmapped = 32'(addr[ADDR_W-1:2]) >= MAP_WORDS;
  assign stat_hit = !unmapped && ((32'(addr[ADDR_W-1:2]) % BANK_WORDS) >= NUM_GROUPS);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

  a_r5_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && stat_hit) |=> $stable(en_all));

  a_r6_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && unmapped) |=> $stable(en_all));

  a_r6_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> (rdata == '0));

  a_r9_two_flop_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (status == $past(src_i, 2)));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    a_r7_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & en_all[c])) |=> irq[c]);
    a_r7_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & en_all[c])) |=> !irq[c]);
  end

endmodule

bind l1irq_agg l1irq_agg_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .NUM_CPUS   (NUM_CPUS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .src_i  (src_i),
  .status (status_q),
  .en_all (en_all),
  .addr   (bus_addr_i),
  .we     (bus_we_i),
  .rdata  (bus_rdata_o),
  .irq    (irq_o)
);

// File: tb/l1irq_agg_tb_top.sv
module l1irq_agg_tb_top;

  localparam int unsigned NG = 4;
  localparam int unsigned NC = 2;
  localparam int unsigned AW = 8;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_SRC = 2'd2; // addr = source group, data = its 32 bits
  localparam logic [1:0] OP_IRQ = 2'd3; // exp[1:0] = expected irq vector

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  8'h00, 32'h0,         32'h0,         8'd1},  // R1 cpu0 enable word 0
    '{OP_RD,  8'h2C, 32'h0,         32'h0,         8'd1},  // R1 cpu1 enable word 3
    '{OP_WR,  8'h0C, 32'h1,         32'h0,         8'd2},  // enable source 0 on cpu0
    '{OP_IRQ, 8'h00, 32'h0,         32'h0,         8'd7},  // R7 enabled but not pending
    '{OP_SRC, 8'd0,  32'h1,         32'h0,         8'd4},  // source 0 high
    '{OP_IRQ, 8'h00, 32'h0,         32'h1,         8'd3},  // R3 last word covers 0..31
    '{OP_RD,  8'h1C, 32'h0,         32'h1,         8'd4},  // R4 status word 3
    '{OP_RD,  8'h10, 32'h0,         32'h0,         8'd3},  // R3 status word 0 = 96..127
    '{OP_RD,  8'h3C, 32'h0,         32'h1,         8'd10}, // R10 cpu1 status, same raw
    '{OP_SRC, 8'd3,  32'h8000_0000, 32'h0,         8'd4},  // source 127 high
    '{OP_RD,  8'h10, 32'h0,         32'h8000_0000, 8'd3},  // R3 R4 not enabled anywhere
    '{OP_WR,  8'h20, 32'h8000_0000, 32'h0,         8'd8},  // cpu1 enables source 127
    '{OP_IRQ, 8'h00, 32'h0,         32'h3,         8'd8},  // R8 both outputs
    '{OP_WR,  8'h0C, 32'h0,         32'h0,         8'd2},  // R2 whole-word replace clears
    '{OP_IRQ, 8'h00, 32'h0,         32'h2,         8'd8},  // R8 only cpu1 left
    '{OP_WR,  8'h10, 32'hFFFF_FFFF, 32'h0,         8'd5},  // write to status
    '{OP_RD,  8'h10, 32'h0,         32'h8000_0000, 8'd5},  // R5 status unchanged
    '{OP_RD,  8'h0C, 32'h0,         32'h0,         8'd5},  // R5 enable untouched
    '{OP_WR,  8'h04, 32'hA5A5_0F0F, 32'h0,         8'd2},
    '{OP_RD,  8'h04, 32'h0,         32'hA5A5_0F0F, 8'd2},  // R2 readback
    '{OP_WR,  8'h04, 32'h1,         32'h0,         8'd2},
    '{OP_RD,  8'h04, 32'h0,         32'h1,         8'd2},  // R2 replaced, not merged
    '{OP_RD,  8'h40, 32'h0,         32'h0,         8'd6},  // R6 first unmapped word
    '{OP_RD,  8'hFC, 32'h0,         32'h0,         8'd6},  // R6 last address
    '{OP_WR,  8'h44, 32'hFFFF_FFFF, 32'h0,         8'd6},  // unmapped write
    '{OP_RD,  8'h04, 32'h0,         32'h1,         8'd6},  // R6 no alias into bank 0
    '{OP_RD,  8'h24, 32'h0,         32'h0,         8'd10}, // R10 cpu1 word 1 separate
    '{OP_SRC, 8'd3,  32'h0,         32'h0,         8'd7},
    '{OP_IRQ, 8'h00, 32'h0,         32'h0,         8'd7},  // R7 output drops
    '{OP_SRC, 8'd0,  32'h0,         32'h0,         8'd7}
  };

  logic                 clk;
  logic                 arst_n;
  logic [NG*32-1:0]     src;
  logic [AW-1:0]        addr;
  logic                 we;
  logic [31:0]          wdata;
  logic [31:0]          rdata;
  logic [NC-1:0]        irq;

  int checks;
  int errors;
  bit done;

  l1irq_agg #(.NUM_GROUPS(NG), .NUM_CPUS(NC), .ADDR_W(AW)) dut_i (
    .clk         (clk),
    .arst_n      (arst_n),
    .src_i       (src),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    arst_n = 1'b0;
    src    = '0;
    addr   = '0;
    we     = 1'b0;
    wdata  = '0;
    repeat (3) @(negedge clk);
    check(32'(irq), 32'h0, "R1 irq in reset");
    check(rdata, 32'h0, "R1 rdata in reset");
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      case (v.op)
        OP_WR: begin
          addr = v.addr; wdata = v.data; we = 1'b1;
          @(negedge clk);
          we = 1'b0;
        end
        OP_RD:  addr = v.addr;
        OP_SRC: src[int'(v.addr)*32 +: 32] = v.data;
        default: ;
      endcase
      repeat (4) @(negedge clk);
      if (v.op == OP_RD) begin
        checks++;
        if (rdata !== v.exp) begin
          errors++;
          $display("FAIL R%0d vector %0d read %h: actual=%h expected=%h",
                   v.tag, i, v.addr, rdata, v.exp);
        end
      end else if (v.op == OP_IRQ) begin
        checks++;
        if (32'(irq) !== v.exp) begin
          errors++;
          $display("FAIL R%0d vector %0d irq: actual=%h expected=%h",
                   v.tag, i, irq, v.exp);
        end
      end
    end

    // R9: exact latency from a source edge to the output
    bus_write(8'h0C, 32'h0000_0020);
    repeat (2) @(negedge clk);
    src[5] = 1'b1;
    @(negedge clk);
    check(32'(irq[0]), 32'h0, "R9 one edge after source");
    @(negedge clk);
    check(32'(irq[0]), 32'h0, "R9 two edges after source");
    @(negedge clk);
    check(32'(irq[0]), 32'h1, "R9 three edges after source");
    check(32'(irq[1]), 32'h0, "R8 cpu1 not enabled for source 5");

    // R7: output falls when the enable is cleared by a whole-word write
    bus_write(8'h0C, 32'h0);
    @(negedge clk);
    check(32'(irq[0]), 32'h0, "R7 low after enable cleared");
    bus_write(8'h0C, 32'h0000_0020);
    @(negedge clk);
    check(32'(irq[0]), 32'h1, "R7 high again after re-enable");

    // R1: reset in the middle of traffic clears enables and outputs
    @(negedge clk);
    arst_n = 1'b0;
    @(negedge clk);
    check(32'(irq), 32'h0, "R1 irq cleared by reset");
    arst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(32'(irq), 32'h0, "R1 irq low after reset with source high");
    bus_read(8'h0C, rd);
    check(rd, 32'h0, "R1 cpu0 enable word 3 after reset");
    bus_read(8'h04, rd);
    check(rd, 32'h0, "R1 cpu0 enable word 1 after reset");
    bus_read(8'h1C, rd);
    check(rd, 32'h0000_0020, "R4 status survives as raw source");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule